// File: doc/BRIEF.md
# Ping-Pong Five-Smallest Distance Selector

This block takes a stream of similarity scores, one per reference sample, and finds the five lowest scores in each group of `M`. Each incoming item is a distance paired with the number of the sample that produced it. The block stores a whole group in one of two on-chip RAM banks. The producer writes into one bank while the other bank is searched. A small two-by-two switch decides which bank takes writes and which bank serves reads. The two banks change roles each time a group is complete.

The search reads the stored group five times. On each read-through it keeps the lowest (distance, sample number) key it has seen, and it skips entries already taken by earlier read-throughs. When the fifth read-through ends, the five keys appear on the outputs in ascending order, together with a one-cycle valid strobe. A pulse marks each completed group, so the upstream stage can move to its next template without waiting for the search. The producer is held off only when both banks still hold groups that have not been fully searched.

Top module: `kmin_pingpong`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `out_valid`, `in_stall` and `next_pixel` are low.
- R2: Each accepted item is stored in the bank that is currently being written. The edge that accepts the `M`-th item of a group makes `next_pixel` high for exactly the next cycle. The following item goes to the other bank.
- R3: When the search engine is idle, `out_valid` is high for one cycle. That cycle is the one after the edge lying 5*M+2 edges after the edge that accepted the last item of the group.
- R4: While `out_valid` is high, slot k (bits k*DW and up of `out_dist`, and k*IW and up of `out_idx`) holds the k-th smallest key of the group. Slot 0 holds the smallest.
- R5: Keys are ordered by distance first. Equal distances are ordered by sample number, lower number first. Identical keys are taken in arrival order.
- R6: An entry chosen by one read-through is never chosen again for the same group. Repeated distance values fill separate slots.
- R7: A complete group is accepted while the previous group is still being searched. The search of the waiting bank starts on the edge after the previous search ends. Its result therefore follows 5*M+2 edges after the earlier strobe.
- R8: `in_stall` is high exactly when both banks hold groups that have not yet been reported. While it is high, `in_valid` is ignored and no item is stored.
- R9: `next_pixel` depends only on the count of accepted items and fires even while a search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An item is offered on `in_dist`/`in_idx` |
| in_dist | input | DW | Distance of the offered item |
| in_idx | input | IW | Sample number of the offered item |
| in_stall | output | 1 | Both banks are busy; the offered item is not taken |
| next_pixel | output | 1 | One-cycle pulse after a group of M items is complete |
| out_valid | output | 1 | One-cycle strobe marking a finished five-key result |
| out_dist | output | 5*DW | Five distances, smallest in the low slot |
| out_idx | output | 5*IW | Sample numbers matching `out_dist` slot by slot |

## Verification
The bench goes after these corner cases:

- **Equal distances with descending sample numbers.** A selector that ignored the sample number in its comparison would report the entries in arrival order. That would put the highest sample numbers first.
- **Three copies of the lowest distance.** A missing mask would report the same entry in every slot.
- **Falling distances, so the minimum arrives last.** This exposes a search that drops the final address or ends one read early.
- **Back-to-back groups that force a stall.** A wrong bank swap, a lost stall, or a search that starts on the wrong bank would show up as a wrong strobe cycle. It would also show up as an item taken during the stall, or as results from the wrong group.

// File: rtl/kmin_pkg.sv
package kmin_pkg;
  // number of keys reported per group
  localparam int KSEL    = 5;
  // largest group size the selector is sized for
  localparam int MAX_SET = 1024;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_READ = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/kmin_bank.sv
module kmin_bank #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 26,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/kmin_xbar.sv
module kmin_xbar #(
  parameter int AW = 6,
  parameter int EW = 26
) (
  input  logic            wr_sel,
  input  logic            wr_en,
  input  logic            rd_sel,
  input  logic            rd_en,
  input  logic [2*EW-1:0] bk_q,
  output logic [1:0]      bk_we,
  output logic [1:0]      bk_re,
  output logic [EW-1:0]   rd_data
);
  for (genvar b = 0; b < 2; b++) begin : g_route
    assign bk_we[b] = wr_en & (wr_sel == 1'(b));
    assign bk_re[b] = rd_en & (rd_sel == 1'(b));
  end

  assign rd_data = rd_sel ? bk_q[2*EW-1:EW] : bk_q[EW-1:0];
endmodule

// File: rtl/kmin_fill_ctl.sv
module kmin_fill_ctl #(
  parameter int M   = 64,
  localparam int AW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          rel,
  input  logic          rel_bank,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bank,
  output logic [1:0]    bank_full,
  output logic          stall,
  output logic          next_pixel
);
  logic [1:0] full_nxt;
  logic       last_wr;

  assign stall   = bank_full[wr_bank];
  assign wr_en   = in_valid & ~stall;
  assign last_wr = wr_en & (wr_addr == AW'(M - 1));

  always_comb begin
    full_nxt = bank_full;
    if (rel)     full_nxt[rel_bank] = 1'b0;
    if (last_wr) full_nxt[wr_bank]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr    <= '0;
      wr_bank    <= 1'b0;
      bank_full  <= '0;
      next_pixel <= 1'b0;
    end else begin
      bank_full  <= full_nxt;
      next_pixel <= last_wr;
      if (last_wr) begin
        wr_addr <= '0;
        wr_bank <= ~wr_bank;
      end else if (wr_en) begin
        wr_addr <= wr_addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/kmin_scan.sv
module kmin_scan
  import kmin_pkg::*;
#(
  parameter int M   = 64,
  parameter int DW  = 16,
  parameter int IW  = 10,
  parameter int K   = KSEL,
  localparam int AW = (M > 1) ? $clog2(M) : 1,
  localparam int PW = (K > 1) ? $clog2(K) : 1,
  localparam int KW = DW + IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bank_full,
  input  logic [KW-1:0] rd_data,
  output logic          rd_bank,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rel,
  output logic          out_valid,
  output logic [K*DW-1:0] out_dist,
  output logic [K*IW-1:0] out_idx
);
  scan_phase_e    phase;
  logic [PW-1:0]  pass;
  logic           dvalid;
  logic [AW-1:0]  d_addr;
  logic [PW-1:0]  d_pass;
  logic           have;
  logic [KW-1:0]  best_key;
  logic [AW-1:0]  best_addr;
  logic [M-1:0]   used;
  logic [KW-1:0]  res_key [K];

  logic           d_first, d_last, cur_have, cand_ok, take, fin, fin_all;
  logic [KW-1:0]  nb_key;
  logic [AW-1:0]  nb_addr;

  assign rd_en = (phase == PH_READ);

  always_comb begin
    d_first  = (d_addr == '0);
    d_last   = (d_addr == AW'(M - 1));
    cur_have = have & ~d_first;
    cand_ok  = ~used[d_addr];
    take     = cand_ok & (~cur_have | (rd_data < best_key));
    nb_key   = take ? rd_data : best_key;
    nb_addr  = take ? d_addr  : best_addr;
    fin      = dvalid & d_last;
    fin_all  = fin & (d_pass == PW'(K - 1));
  end

  assign rel = fin_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      pass      <= '0;
      rd_addr   <= '0;
      rd_bank   <= 1'b0;
      dvalid    <= 1'b0;
      d_addr    <= '0;
      d_pass    <= '0;
      have      <= 1'b0;
      best_key  <= '0;
      best_addr <= '0;
      used      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fin_all;
      dvalid    <= (phase == PH_READ);
      d_addr    <= rd_addr;
      d_pass    <= pass;

      case (phase)
        PH_IDLE: begin
          if (!dvalid && bank_full[rd_bank]) begin
            phase   <= PH_READ;
            rd_addr <= '0;
            pass    <= '0;
            used    <= '0;
          end
        end
        default: begin
          if (rd_addr == AW'(M - 1)) begin
            rd_addr <= '0;
            if (pass == PW'(K - 1)) phase <= PH_IDLE;
            else                    pass  <= pass + PW'(1);
          end else begin
            rd_addr <= rd_addr + AW'(1);
          end
        end
      endcase

      if (dvalid) begin
        have      <= cur_have | cand_ok;
        best_key  <= nb_key;
        best_addr <= nb_addr;
      end
      if (fin)     used[nb_addr] <= 1'b1;
      if (fin_all) rd_bank       <= ~rd_bank;
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                           res_key[k] <= '0;
      else if (fin && d_pass == PW'(k))  res_key[k] <= nb_key;
    end
    assign out_dist[k*DW +: DW] = res_key[k][KW-1:IW];
    assign out_idx[k*IW +: IW]  = res_key[k][IW-1:0];
  end
endmodule

// File: rtl/kmin_pingpong.sv
module kmin_pingpong
  import kmin_pkg::*;
#(
  parameter int M   = 64,
  parameter int DW  = 16,
  parameter int IW  = 10,
  localparam int K  = KSEL,
  localparam int AW = (M > 1) ? $clog2(M) : 1,
  localparam int EW = DW + IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_dist,
  input  logic [IW-1:0]   in_idx,
  output logic            in_stall,
  output logic            next_pixel,
  output logic            out_valid,
  output logic [K*DW-1:0] out_dist,
  output logic [K*IW-1:0] out_idx
);
  logic          wr_en, wr_bank, rd_en, rd_bank, rel;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [1:0]    bank_full, bk_we, bk_re;
  logic [2*EW-1:0] bk_q;
  logic [EW-1:0] rd_data;

  kmin_fill_ctl #(.M(M)) u_fill (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rel(rel), .rel_bank(rd_bank),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bank(wr_bank), .bank_full(bank_full),
    .stall(in_stall), .next_pixel(next_pixel)
  );

  kmin_xbar #(.AW(AW), .EW(EW)) u_xbar (
    .wr_sel(wr_bank), .wr_en(wr_en), .rd_sel(rd_bank), .rd_en(rd_en),
    .bk_q(bk_q), .bk_we(bk_we), .bk_re(bk_re), .rd_data(rd_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    kmin_bank #(.DEPTH(M), .WIDTH(EW)) u_ram (
      .clk(clk), .we(bk_we[b]), .waddr(wr_addr), .wdata({in_dist, in_idx}),
      .re(bk_re[b]), .raddr(rd_addr), .rdata(bk_q[b*EW +: EW])
    );
  end

  kmin_scan #(.M(M), .DW(DW), .IW(IW), .K(K)) u_scan (
    .clk(clk), .rst(rst), .bank_full(bank_full), .rd_data(rd_data),
    .rd_bank(rd_bank), .rd_en(rd_en), .rd_addr(rd_addr), .rel(rel),
    .out_valid(out_valid), .out_dist(out_dist), .out_idx(out_idx)
  );
endmodule

// File: rtl/kmin_pingpong_chk.sv
module kmin_pingpong_chk #(
  parameter int DW = 16,
  parameter int IW = 10,
  parameter int K  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_stall,
  input logic            next_pixel,
  input logic            out_valid,
  input logic [K*DW-1:0] out_dist,
  input logic [K*IW-1:0] out_idx
);
  logic [1:0] pend;
  logic [2:0] held_now;
  logic       ordered;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= 2'(held_now);
  end

  assign held_now = {1'b0, pend} + 3'(next_pixel) - 3'(out_valid);

  always_comb begin
    ordered = 1'b1;
    for (int k = 0; k < K - 1; k++) begin
      if ({out_dist[k*DW +: DW], out_idx[k*IW +: IW]} >
          {out_dist[(k+1)*DW +: DW], out_idx[(k+1)*IW +: IW]})
        ordered = 1'b0;
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4
  order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ordered);

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    in_stall == (held_now == 3'd2));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    held_now <= 3'd2);

  // R2
  adv_gap_chk: assert property (@(posedge clk) disable iff (rst)
    next_pixel |=> !next_pixel);

  // R7
  out_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pend != 2'd0));
endmodule

bind kmin_pingpong kmin_pingpong_chk #(.DW(DW), .IW(IW), .K(K)) u_chk (
  .clk(clk), .rst(rst), .in_stall(in_stall), .next_pixel(next_pixel),
  .out_valid(out_valid), .out_dist(out_dist), .out_idx(out_idx)
);

// File: tb/kmin_pingpong_tb.sv
module kmin_pingpong_tb;
  localparam int M  = 8;
  localparam int DW = 12;
  localparam int IW = 6;
  localparam int K  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_dist = '0;
  logic [IW-1:0] in_idx = '0;
  logic in_stall, next_pixel, out_valid;
  logic [K*DW-1:0] out_dist;
  logic [K*IW-1:0] out_idx;

  always #4 clk = ~clk;

  kmin_pingpong #(.M(M), .DW(DW), .IW(IW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dist(in_dist), .in_idx(in_idx),
    .in_stall(in_stall), .next_pixel(next_pixel), .out_valid(out_valid),
    .out_dist(out_dist), .out_idx(out_idx)
  );

  int nchk = 0;
  int nfail = 0;
  string cur_req = "R4";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int cur_d[$], cur_i[$];
  int fill_edge[$];
  int top_d[$], top_i[$];
  int held = 0, scnt = 0, ecount = 0;
  bit scanning = 0;
  bit e_stall = 0, e_adv = 0, e_ov = 0;
  int e_d[K], e_i[K];

  function automatic void take_top();
    bit u[M];
    for (int j = 0; j < M; j++) u[j] = 0;
    for (int k = 0; k < K; k++) begin
      int b = -1;
      for (int j = 0; j < M; j++)
        if (!u[j] && (b < 0 || cur_d[j] < cur_d[b] ||
            (cur_d[j] == cur_d[b] && cur_i[j] < cur_i[b]))) b = j;
      u[b] = 1;
      top_d.push_back(cur_d[b]);
      top_i.push_back(cur_i[b]);
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cur_d.delete(); cur_i.delete(); fill_edge.delete(); top_d.delete(); top_i.delete();
      held = 0; scnt = 0; ecount = 0; scanning = 0;
      e_stall = 0; e_adv = 0; e_ov = 0;
    end else begin
      ecount++;
      e_adv = 0;
      e_ov = 0;
      if (scanning) begin
        scnt--;
        if (scnt == 0) begin
          scanning = 0;
          e_ov = 1;
          held--;
          for (int k = 0; k < K; k++) begin
            e_d[k] = top_d.pop_front();
            e_i[k] = top_i.pop_front();
          end
        end
      end else if (fill_edge.size() > 0 && fill_edge[0] < ecount) begin
        void'(fill_edge.pop_front());
        scanning = 1;
        scnt = 5 * M + 1;
      end
      if (in_valid && !e_stall) begin
        cur_d.push_back(int'(in_dist));
        cur_i.push_back(int'(in_idx));
        if (cur_d.size() == M) begin
          take_top();
          fill_edge.push_back(ecount);
          held++;
          e_adv = 1;
          cur_d.delete();
          cur_i.delete();
        end
      end
      e_stall = (held == 2);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8", "in_stall", int'(in_stall), int'(e_stall));
      chk("R9", "next_pixel", int'(next_pixel), int'(e_adv));
      chk("R3", "out_valid", int'(out_valid), int'(e_ov));
      if (out_valid && e_ov) begin
        for (int k = 0; k < K; k++) begin
          chk({"R4 ", cur_req}, $sformatf("dist slot %0d", k), int'(out_dist[k*DW +: DW]), e_d[k]);
          chk({"R4 ", cur_req}, $sformatf("idx slot %0d", k), int'(out_idx[k*IW +: IW]), e_i[k]);
        end
      end
    end
  end

  task automatic send(int d, int i);
    bit st;
    @(negedge clk);
    in_valid = 1'b1;
    in_dist = DW'(d);
    in_idx = IW'(i);
    forever begin
      st = in_stall;
      @(posedge clk);
      if (!st) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_set(int mode, int base, bit gaps);
    for (int j = 0; j < M; j++) begin
      int d, i;
      case (mode)
        0: begin d = int'($urandom_range(4095)); i = base + j; end
        1: begin d = 100; i = base + M - 1 - j; end
        2: begin d = 4000 - 3 * j; i = base + j; end
        3: begin d = (j % 3) * 7; i = base + j; end
        default: begin d = 4095; i = base + (j * 5) % M; end
      endcase
      send(d, i);
      if (gaps) idle(1);
    end
  endtask

  task automatic drain();
    int w = 0;
    while ((scanning || fill_edge.size() > 0 || top_d.size() > 0) && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R1 outputs quiet in reset
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "in_stall in reset", int'(in_stall), 0);
      chk("R1", "next_pixel in reset", int'(next_pixel), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    // R2 R3 R4 single random group
    cur_req = "R2";
    send_set(0, 0, 0); idle(1); drain();
    // R5 equal distances, descending sample numbers
    cur_req = "R5";
    send_set(1, 10, 0); idle(1); drain();
    // R6 repeated lowest distance must fill separate slots
    cur_req = "R6";
    send_set(3, 20, 0); idle(1); drain();
    // minimum arrives last; all-max distances
    cur_req = "R4";
    send_set(2, 30, 0); idle(1); drain();
    send_set(4, 40, 0); idle(1); drain();
    // R7 R8 R9 back-to-back groups force stall and overlap
    cur_req = "R7";
    send_set(0, 0, 0);
    send_set(2, 8, 0);
    send_set(1, 16, 0);
    send_set(3, 24, 0);
    idle(1); drain();
    // gaps in valid
    cur_req = "R2";
    send_set(0, 50, 1); idle(1); drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule